// File: doc/BRIEF.md
# ECC Partial-Write Read-Modify-Write Engine

This block sits between a local write-request port and a memory command port. Memory stores every 64-bit data word together with 8 check bits of a single-error-correcting, double-error-detecting (SECDED) code. When a request enables every byte lane, the engine encodes the new word and issues one write.

When any lane is disabled, the engine runs a read-modify-write instead. It reads the stored codeword and decodes it, correcting a single-bit error if there is one. It then combines the enabled new bytes with the remaining stored bytes, computes fresh check bits and writes the result back to the same address. A request with no lanes enabled therefore rewrites the corrected stored word, which scrubs the location.

Errors found during the read update saturating single-bit and double-bit counters. They also raise a one-cycle interrupt pulse and record the failing address and the error type. The local port takes one request at a time and stays not-ready until the last memory command of that request has been accepted.

Top module: `ecc_rmw_engine`

## Requirements
- R1: Codeword layout. The 64 data bits fill Hamming positions 1 to 71 in ascending order, skipping the powers of two. Check bit k (k = 0..6) is the XOR of all data bits whose position has bit k set. Check bit 7 is the XOR of all 64 data bits and check bits 0..6, so every written data-plus-check word has even overall parity.
- R2: A request with all 8 byte enables set produces exactly one write command and no read. That write carries the request address, the request data and its check bits.
- R3: A request with any byte enable clear first issues a read command to the request address. After that comes exactly one write command to the same address.
- R4: Byte lane l is data bits 8l+7..8l and is controlled by byte enable bit l. In the write-back word, each enabled lane holds the new data and each disabled lane holds the stored data.
- R5: When the read returns a single-bit error, in a data bit or in a check bit, the stored data is corrected before merging. The single-bit counter then increments, errIrq pulses for one cycle, errAddr takes the request address and errDouble goes to 0.
- R6: When the read returns a double-bit error, the double-bit counter increments, errIrq pulses for one cycle, errAddr takes the request address and errDouble goes to 1. The write-back word combines the enabled new bytes with the uncorrected returned bytes and carries freshly computed check bits.
- R7: A request with all byte enables clear writes the corrected stored word back to its address with valid check bits.
- R8: reqReady is high when the engine is idle. It is low from the cycle after a request is accepted until the cycle after the last write command is accepted, and it is never high while a memory command is pending.
- R9: Each error counter saturates at its all-ones value. cntClear zeroes both counters on the next clock edge and takes priority over an increment in the same cycle.
- R10: While memCmdValid is high and memCmdReady is low, the command, address, data and check bits stay unchanged.
- R11: After reset, reqReady is high, memCmdValid and errIrq are low, and both counters are zero.
- R12: A read that returns a clean codeword leaves both counters unchanged and raises no errIrq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Local write request present |
| reqReady | output | 1 | Engine accepts a request |
| reqAddr | input | ADDR_W | Request address |
| reqData | input | 64 | Request write data |
| reqBe | input | 8 | Request byte enables, bit l for lane l |
| memCmdValid | output | 1 | Memory command present |
| memCmdReady | input | 1 | Memory accepts the command |
| memCmdWrite | output | 1 | 1 = write command, 0 = read command |
| memCmdAddr | output | ADDR_W | Command address |
| memWrData | output | 64 | Write data |
| memWrChk | output | 8 | Write check bits |
| memRdValid | input | 1 | Read return valid |
| memRdData | input | 64 | Returned stored data |
| memRdChk | input | 8 | Returned stored check bits |
| cntClear | input | 1 | Zero both error counters |
| sbeCount | output | CNT_W | Single-bit error count |
| dbeCount | output | CNT_W | Double-bit error count |
| errIrq | output | 1 | One-cycle error pulse |
| errAddr | output | ADDR_W | Address of the last error |
| errDouble | output | 1 | Last error was double-bit |

## Verification
The bench injects single-bit flips at every codeword position, including the check bits and the overall parity bit. A decoder that treats check-bit flips as data flips would corrupt a data byte, and a wrong position table would flip the wrong bit. Double flips confirm that the raw bytes, not a miscorrected word, end up in the disabled lanes, and that the double counter moves and the single counter does not. Requests with no lanes enabled and with all lanes enabled expose an engine that skips the read or issues one it should not. Memory back-pressure and a counter shortened to 3 bits expose a command that changes while stalled and a counter that wraps instead of holding.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;

  localparam int DataW = 64;
  localparam int LaneW = 8;
  localparam int LaneN = DataW / LaneW;

  function automatic int hamBits(int n);
    int r = 1;
    while ((1 << r) < n + r + 1) r++;
    return r;
  endfunction

  localparam int HamW  = hamBits(DataW);
  localparam int ChkW  = HamW + 1;
  localparam int LastPos = DataW + HamW;

  typedef logic [DataW-1:0] word_t;
  typedef logic [ChkW-1:0]  chk_t;
  typedef logic [HamW-1:0]  syn_t;

  typedef struct packed {
    logic capture;
    logic loadMerge;
    logic cmdValid;
    logic cmdWrite;
  } strobe_t;

  function automatic chk_t secdedEncode(word_t d);
    chk_t c = '0;
    int   j = 0;
    for (int p = 1; p <= LastPos; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int k = 0; k < HamW; k++) begin
          if (p[k]) c[k] = c[k] ^ d[j];
        end
        j++;
      end
    end
    c[HamW] = (^d) ^ (^c[HamW-1:0]);
    return c;
  endfunction

  function automatic word_t secdedFix(word_t d, syn_t syn);
    word_t r = d;
    int    j = 0;
    for (int p = 1; p <= LastPos; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (int'(syn) == p) r[j] = ~r[j];
        j++;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/ecc_rmw_secded_dec.sv
module ecc_rmw_secded_dec
  import ecc_rmw_pkg::*;
(
  input  word_t rdData,
  input  chk_t  rdChk,
  output word_t fixData,
  output logic  isSingle,
  output logic  isDouble
);

  chk_t reCalc;
  syn_t syndrome;
  logic parityOdd;
  logic synInRange;

  always_comb begin
    reCalc     = secdedEncode(rdData);
    syndrome   = rdChk[HamW-1:0] ^ reCalc[HamW-1:0];
    parityOdd  = ^{rdData, rdChk};
    synInRange = (int'(syndrome) <= LastPos);
    isSingle   = parityOdd && synInRange;
    isDouble   = (!parityOdd && (syndrome != '0)) || (parityOdd && !synInRange);
    fixData    = isSingle ? secdedFix(rdData, syndrome) : rdData;
  end

endmodule

// File: rtl/ecc_rmw_ctrl.sv
module ecc_rmw_ctrl
  import ecc_rmw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    allBe,
  input  logic    memCmdReady,
  input  logic    memRdValid,
  output logic    reqReady,
  output strobe_t stb
);

  typedef enum logic [1:0] {
    S_IDLE,
    S_RD_CMD,
    S_RD_WAIT,
    S_WR_CMD
  } state_t;

  state_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:    if (reqValid) stateNext = allBe ? S_WR_CMD : S_RD_CMD;
      S_RD_CMD:  if (memCmdReady) stateNext = S_RD_WAIT;
      S_RD_WAIT: if (memRdValid) stateNext = S_WR_CMD;
      S_WR_CMD:  if (memCmdReady) stateNext = S_IDLE;
      default:   stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    reqReady      = (state == S_IDLE);
    stb.capture   = (state == S_IDLE) && reqValid;
    stb.loadMerge = (state == S_RD_WAIT) && memRdValid;
    stb.cmdValid  = (state == S_RD_CMD) || (state == S_WR_CMD);
    stb.cmdWrite  = (state == S_WR_CMD);
  end

endmodule

// File: rtl/ecc_rmw_datapath.sv
module ecc_rmw_datapath
  import ecc_rmw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  word_t             reqData,
  input  logic [LaneN-1:0]  reqBe,
  input  word_t             memRdData,
  input  chk_t              memRdChk,
  input  logic              cntClear,
  output logic              memCmdValid,
  output logic              memCmdWrite,
  output logic [ADDR_W-1:0] memCmdAddr,
  output word_t             memWrData,
  output chk_t              memWrChk,
  output logic [CNT_W-1:0]  sbeCount,
  output logic [CNT_W-1:0]  dbeCount,
  output logic              errIrq,
  output logic [ADDR_W-1:0] errAddr,
  output logic              errDouble
);

  localparam logic [CNT_W-1:0] CntMax = '1;

  logic [ADDR_W-1:0] addrQ;
  word_t             newQ;
  logic [LaneN-1:0]  beQ;
  word_t             wordQ;

  word_t fixData;
  word_t baseWord;
  word_t mergeWord;
  logic  rdSingle;
  logic  rdDouble;

  ecc_rmw_secded_dec u_dec (
    .rdData  (memRdData),
    .rdChk   (memRdChk),
    .fixData (fixData),
    .isSingle(rdSingle),
    .isDouble(rdDouble)
  );

  assign baseWord = rdDouble ? memRdData : fixData;

  for (genvar l = 0; l < LaneN; l++) begin : g_lane
    assign mergeWord[l*LaneW +: LaneW] =
      beQ[l] ? newQ[l*LaneW +: LaneW] : baseWord[l*LaneW +: LaneW];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      newQ  <= '0;
      beQ   <= '0;
      wordQ <= '0;
    end else if (stb.capture) begin
      addrQ <= reqAddr;
      newQ  <= reqData;
      beQ   <= reqBe;
      wordQ <= reqData;
    end else if (stb.loadMerge) begin
      wordQ <= mergeWord;
    end
  end

  function automatic logic [CNT_W-1:0] satInc(logic [CNT_W-1:0] v);
    return (v == CntMax) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sbeCount <= '0;
      dbeCount <= '0;
    end else if (cntClear) begin
      sbeCount <= '0;
      dbeCount <= '0;
    end else if (stb.loadMerge) begin
      if (rdSingle) sbeCount <= satInc(sbeCount);
      if (rdDouble) dbeCount <= satInc(dbeCount);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errIrq    <= 1'b0;
      errAddr   <= '0;
      errDouble <= 1'b0;
    end else begin
      errIrq <= stb.loadMerge && (rdSingle || rdDouble);
      if (stb.loadMerge && (rdSingle || rdDouble)) begin
        errAddr   <= addrQ;
        errDouble <= rdDouble;
      end
    end
  end

  always_comb begin
    memCmdValid = stb.cmdValid;
    memCmdWrite = stb.cmdWrite;
    memCmdAddr  = addrQ;
    memWrData   = wordQ;
    memWrChk    = secdedEncode(wordQ);
  end

endmodule

// File: rtl/ecc_rmw_engine.sv
module ecc_rmw_engine
  import ecc_rmw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DataW-1:0]  reqData,
  input  logic [LaneN-1:0]  reqBe,
  output logic              memCmdValid,
  input  logic              memCmdReady,
  output logic              memCmdWrite,
  output logic [ADDR_W-1:0] memCmdAddr,
  output logic [DataW-1:0]  memWrData,
  output logic [ChkW-1:0]   memWrChk,
  input  logic              memRdValid,
  input  logic [DataW-1:0]  memRdData,
  input  logic [ChkW-1:0]   memRdChk,
  input  logic              cntClear,
  output logic [CNT_W-1:0]  sbeCount,
  output logic [CNT_W-1:0]  dbeCount,
  output logic              errIrq,
  output logic [ADDR_W-1:0] errAddr,
  output logic              errDouble
);

  strobe_t stb;

  ecc_rmw_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .allBe      (&reqBe),
    .memCmdReady(memCmdReady),
    .memRdValid (memRdValid),
    .reqReady   (reqReady),
    .stb        (stb)
  );

  ecc_rmw_datapath #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .reqBe      (reqBe),
    .memRdData  (memRdData),
    .memRdChk   (memRdChk),
    .cntClear   (cntClear),
    .memCmdValid(memCmdValid),
    .memCmdWrite(memCmdWrite),
    .memCmdAddr (memCmdAddr),
    .memWrData  (memWrData),
    .memWrChk   (memWrChk),
    .sbeCount   (sbeCount),
    .dbeCount   (dbeCount),
    .errIrq     (errIrq),
    .errAddr    (errAddr),
    .errDouble  (errDouble)
  );

endmodule

// File: rtl/ecc_rmw_checker.sv
module ecc_rmw_checker
  import ecc_rmw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [DataW-1:0]  reqData,
  input logic [LaneN-1:0]  reqBe,
  input logic              memCmdValid,
  input logic              memCmdReady,
  input logic              memCmdWrite,
  input logic [ADDR_W-1:0] memCmdAddr,
  input logic [DataW-1:0]  memWrData,
  input logic [ChkW-1:0]   memWrChk,
  input logic              cntClear,
  input logic [CNT_W-1:0]  sbeCount,
  input logic [CNT_W-1:0]  dbeCount,
  input logic              errIrq
);

  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    memCmdValid |-> !reqReady);

  a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rstN)
    memCmdValid && !memCmdReady |=> memCmdValid && $stable(memCmdWrite) &&
      $stable(memCmdAddr) && $stable(memWrData) && $stable(memWrChk));

  a_r1_even_parity: assert property (@(posedge clk) disable iff (!rstN)
    memCmdValid && memCmdWrite |-> (^{memWrData, memWrChk}) == 1'b0);

  a_r2_full_direct: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && (&reqBe) |=> memCmdValid && memCmdWrite &&
      memWrData == $past(reqData) && memCmdAddr == $past(reqAddr));

  a_r3_read_first: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !(&reqBe) |=> memCmdValid && !memCmdWrite &&
      memCmdAddr == $past(reqAddr));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    cntClear |=> sbeCount == '0 && dbeCount == '0);

  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    !cntClear |=> sbeCount >= $past(sbeCount) && dbeCount >= $past(dbeCount));

  a_r5_irq_pulse: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |=> !errIrq);

endmodule

bind ecc_rmw_engine ecc_rmw_checker #(
  .ADDR_W(ADDR_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqAddr    (reqAddr),
  .reqData    (reqData),
  .reqBe      (reqBe),
  .memCmdValid(memCmdValid),
  .memCmdReady(memCmdReady),
  .memCmdWrite(memCmdWrite),
  .memCmdAddr (memCmdAddr),
  .memWrData  (memWrData),
  .memWrChk   (memWrChk),
  .cntClear   (cntClear),
  .sbeCount   (sbeCount),
  .dbeCount   (dbeCount),
  .errIrq     (errIrq)
);

// File: tb/sim_ecc_rmw_engine.sv
module sim_ecc_rmw_engine;

  localparam int AW   = 32;
  localparam int CW   = 3;
  localparam int MEMN = 16;
  localparam int CMAX = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [AW-1:0] reqAddr = '0;
  logic [63:0]   reqData = '0;
  logic [7:0]    reqBe = '0;
  logic          memCmdValid;
  logic          memCmdReady = 1'b0;
  logic          memCmdWrite;
  logic [AW-1:0] memCmdAddr;
  logic [63:0]   memWrData;
  logic [7:0]    memWrChk;
  logic          memRdValid = 1'b0;
  logic [63:0]   memRdData = '0;
  logic [7:0]    memRdChk = '0;
  logic          cntClear = 1'b0;
  logic [CW-1:0] sbeCount;
  logic [CW-1:0] dbeCount;
  logic          errIrq;
  logic [AW-1:0] errAddr;
  logic          errDouble;

  ecc_rmw_engine #(.ADDR_W(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqData(reqData), .reqBe(reqBe),
    .memCmdValid(memCmdValid), .memCmdReady(memCmdReady),
    .memCmdWrite(memCmdWrite), .memCmdAddr(memCmdAddr),
    .memWrData(memWrData), .memWrChk(memWrChk),
    .memRdValid(memRdValid), .memRdData(memRdData), .memRdChk(memRdChk),
    .cntClear(cntClear), .sbeCount(sbeCount), .dbeCount(dbeCount),
    .errIrq(errIrq), .errAddr(errAddr), .errDouble(errDouble)
  );

  int errs = 0;
  int checks = 0;

  task automatic check(bit ok, string req, string what, logic [71:0] act, logic [71:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference SECDED check bits, from the codeword layout of R1.
  function automatic logic [7:0] refChk(logic [63:0] d);
    logic [7:0] c = '0;
    int p = 2;
    for (int j = 0; j < 64; j++) begin
      p++;
      while ((p & (p - 1)) == 0) p++;
      for (int k = 0; k < 7; k++) if (((p >> k) & 1) == 1) c[k] ^= d[j];
    end
    c[7] = (^d) ^ (^c[6:0]);
    return c;
  endfunction

  function automatic logic [63:0] refMerge(logic [63:0] base, logic [63:0] nw, logic [7:0] be);
    logic [63:0] r = base;
    for (int l = 0; l < 8; l++) if (be[l]) r[l*8 +: 8] = nw[l*8 +: 8];
    return r;
  endfunction

  // Memory model
  logic [63:0] memD [MEMN];
  logic [7:0]  memC [MEMN];
  logic [63:0] clean [MEMN];
  int          rdPend = 0;
  logic [63:0] rdDataQ;
  logic [7:0]  rdChkQ;
  int          nRd, nWr, irqCnt;
  bit          readyBad, orderBad;
  logic [AW-1:0] wrAddr, rdAddr;
  int          expS = 0, expD = 0;

  always @(negedge clk) begin
    if (rstN) begin
      memRdValid = 1'b0;
      if (rdPend > 0) begin
        rdPend--;
        if (rdPend == 0) begin
          memRdValid = 1'b1;
          memRdData  = rdDataQ;
          memRdChk   = rdChkQ;
        end
      end
      memCmdReady = ($urandom % 4) != 0;
      #1;
      if (memCmdValid && memCmdReady) begin
        if (reqReady) readyBad = 1'b1;
        if (memCmdWrite) begin
          nWr++;
          wrAddr = memCmdAddr;
          memD[memCmdAddr[3:0]] = memWrData;
          memC[memCmdAddr[3:0]] = memWrChk;
        end else begin
          if (nWr != 0) orderBad = 1'b1;
          nRd++;
          rdAddr  = memCmdAddr;
          rdDataQ = memD[memCmdAddr[3:0]];
          rdChkQ  = memC[memCmdAddr[3:0]];
          rdPend  = 2;
        end
      end
      if (errIrq) irqCnt++;
    end
  end

  task automatic flipBit(int idx, int b);
    if (b < 64) memD[idx][b] = ~memD[idx][b];
    else        memC[idx][b-64] = ~memC[idx][b-64];
  endtask

  // kind: 0 none, 1 single-bit flip at pos b1, 2 double flip at b1/b2
  task automatic doOp(logic [AW-1:0] addr, logic [63:0] data, logic [7:0] be,
                      int kind, int b1, int b2);
    int idx = int'(addr[3:0]);
    logic [63:0] base, expW;
    int effKind;
    int wait_n;
    string rq;
    if (kind >= 1) flipBit(idx, b1);
    if (kind == 2) flipBit(idx, b2);
    effKind = (be == 8'hFF) ? 0 : kind;
    base = (effKind == 2) ? memD[idx] : clean[idx];
    expW = refMerge(base, data, be);
    if (effKind == 1 && expS < CMAX) expS++;
    if (effKind == 2 && expD < CMAX) expD++;
    nRd = 0; nWr = 0; irqCnt = 0; readyBad = 0; orderBad = 0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqData = data; reqBe = be;
    #2;
    while (!reqReady) begin @(negedge clk); #2; end
    @(negedge clk);
    reqValid = 1'b0;
    wait_n = 0;
    #2;
    while (!reqReady && wait_n < 200) begin @(negedge clk); #2; wait_n++; end
    rq = (be == 8'hFF) ? "R2" : "R3";
    check(nWr == 1, rq, "write count", 72'(nWr), 72'd1);
    check(nRd == ((be == 8'hFF) ? 0 : 1), rq, "read count", 72'(nRd), 72'((be == 8'hFF) ? 0 : 1));
    check(wrAddr == addr, rq, "write address", 72'(wrAddr), 72'(addr));
    if (be != 8'hFF) check(rdAddr == addr && !orderBad, "R3", "read before write", 72'(rdAddr), 72'(addr));
    rq = (effKind == 2) ? "R6" : ((be == 8'h00) ? "R7" : "R4");
    check(memD[idx] == expW, rq, "stored word", 72'(memD[idx]), 72'(expW));
    check(memC[idx] == refChk(expW), "R1", "stored check bits", 72'(memC[idx]), 72'(refChk(expW)));
    check(!readyBad, "R8", "ready while command pending", 72'(readyBad), 72'd0);
    rq = (effKind == 0) ? "R12" : ((effKind == 1) ? "R5" : "R6");
    check(int'(sbeCount) == expS, rq, "single count", 72'(sbeCount), 72'(expS));
    check(int'(dbeCount) == expD, rq, "double count", 72'(dbeCount), 72'(expD));
    check(irqCnt == ((effKind != 0) ? 1 : 0), rq, "irq pulses", 72'(irqCnt), 72'((effKind != 0) ? 1 : 0));
    if (effKind != 0) begin
      check(errAddr == addr, rq, "error address", 72'(errAddr), 72'(addr));
      check(errDouble == (effKind == 2), rq, "error type", 72'(errDouble), 72'(effKind == 2));
    end
    clean[idx] = expW;
  endtask

  task automatic clearCounters();
    @(negedge clk);
    cntClear = 1'b1;
    @(negedge clk);
    cntClear = 1'b0;
    #2;
    expS = 0; expD = 0;
    check(sbeCount == '0 && dbeCount == '0, "R9", "counters after clear",
          72'({sbeCount, dbeCount}), 72'd0);
  endtask

  initial begin
    #(8 * 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EC0DE));
    for (int i = 0; i < MEMN; i++) begin
      clean[i] = {$urandom, $urandom};
      memD[i]  = clean[i];
      memC[i]  = refChk(clean[i]);
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #2;
    // R11 reset state
    check(reqReady == 1'b1, "R11", "ready after reset", 72'(reqReady), 72'd1);
    check(memCmdValid == 1'b0 && errIrq == 1'b0, "R11", "cmd/irq after reset",
          72'({memCmdValid, errIrq}), 72'd0);
    check(sbeCount == '0 && dbeCount == '0, "R11", "counters after reset",
          72'({sbeCount, dbeCount}), 72'd0);

    // R2 full write, R1 encoding of a known pattern
    doOp(32'h0000_1230, 64'h0123_4567_89AB_CDEF, 8'hFF, 0, 0, 0);
    // R4 / R12 partial merge without error
    doOp(32'h0000_0A01, 64'hFFEE_DDCC_BBAA_9988, 8'h5A, 0, 0, 0);
    // R7 / R5 scrub with a data-bit error
    doOp(32'h0000_0002, 64'h0, 8'h00, 1, 37, 0);
    // R5 single error in a Hamming check bit and in the overall parity bit
    doOp(32'h0000_0003, 64'hAAAA_5555_AAAA_5555, 8'h0F, 1, 66, 0);
    doOp(32'h0000_0004, 64'h1111_2222_3333_4444, 8'hF0, 1, 71, 0);
    // R6 double error
    doOp(32'h0000_0005, 64'hDEAD_BEEF_CAFE_F00D, 8'h3C, 2, 3, 60);
    // R2 full write over a corrupted word: no read, no count
    doOp(32'h0000_0006, 64'h7777_0000_7777_0000, 8'hFF, 2, 1, 2);
    // R5 every single-bit position
    for (int b = 0; b < 72; b++)
      doOp(32'h0000_0007 + 32'(b[3:0] << 4), {$urandom, $urandom}, 8'($urandom), 1, b, 0);
    // R9 saturation
    clearCounters();
    for (int i = 0; i < CMAX + 2; i++)
      doOp(32'h0000_0008, {$urandom, $urandom}, 8'h01, 1, i, 0);
    check(int'(sbeCount) == CMAX, "R9", "single count saturated", 72'(sbeCount), 72'(CMAX));
    for (int i = 0; i < CMAX + 2; i++)
      doOp(32'h0000_0009, {$urandom, $urandom}, 8'h80, 2, i, i + 20);
    check(int'(dbeCount) == CMAX, "R9", "double count saturated", 72'(dbeCount), 72'(CMAX));
    clearCounters();

    // Random mix
    for (int n = 0; n < 300; n++) begin
      int r = $urandom % 10;
      int kind = (r < 5) ? 0 : ((r < 8) ? 1 : 2);
      int b1 = $urandom % 72;
      int b2 = (b1 + 1 + ($urandom % 71)) % 72;
      logic [7:0] be;
      r = $urandom % 6;
      be = (r == 0) ? 8'hFF : ((r == 1) ? 8'h00 : 8'($urandom));
      doOp({$urandom}, {$urandom, $urandom}, be, kind, b1, b2);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule